// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 level-sensitive interrupt lines from peripherals and presents them to a processor on two outputs: an ordinary interrupt request and a fast interrupt request. Software enables each source with a mask bit and sends it to one output or the other with a steering bit. It can read the raw line state and the pending set for each output. A table of programmable priority slots sets which pending source is reported first.

Two "highest pending" words each report one winning source, as an encoded number with a valid flag. One covers the ordinary output and one covers the fast output. A handler can read one of them, service the source it names, and loop until the valid flag reads zero. A wake output tells the power controller that the core should leave idle. A control bit decides whether masked sources may also cause that wake. Sources are not latched, so every pending view follows the input lines as they are.

Top module: `prio_intc`

## Requirements
- R1: After reset every register reads zero and `irq_o`, `fiq_o`, `wake_o` and `rvalid_o` are low. All sources therefore start disabled and steered to the ordinary output.
- R2: A mask bit (word 0x04, bit n for source n) of 1 enables source n and 0 disables it. A disabled source adds nothing to any pending word or to either interrupt output. A mask write acts on the outputs in the cycle after the write is accepted.
- R3: Steering bit n (word 0x08) set to 0 sends source n to the ordinary output and set to 1 sends it to the fast output. Word 0x00 reads `src & mask & ~steer`, word 0x0C reads `src & mask & steer`, and word 0x10 reads the raw source lines.
- R4: Sources are level-sensitive and nothing is latched. When a line deasserts, its pending bit and the output it drove clear without any acknowledge.
- R5: `irq_o` is the registered OR of the word 0x00 value and `fiq_o` is the registered OR of the word 0x0C value. Each follows its inputs one clock edge later.
- R6: Word 0x18 reports the ordinary-output winner. Bit 31 is the valid flag, bits 30:16 hold the source number and all other bits are zero. The whole word reads zero when nothing in word 0x00 is pending.
- R7: Slot k sits at address 0x1C + 4k and holds a valid flag in bit 31 and a source number in bits 4:0. Other bits read back as zero. The winner is the source of the lowest-numbered valid slot whose source is in the pending set, so slot 0 has the highest priority. Slots that are not valid are skipped.
- R8: When no valid slot names a pending source, the winner is the highest-numbered pending source.
- R9: The word just past the last slot (0x9C) reports the fast-output winner in the same format. It applies the same slot and fallback rules to the word 0x0C set.
- R10: `wake_o` is registered. With control bit 0 (word 0x14) clear, it is high when any raw line is high. With the bit set, it is high only when some enabled source is high.
- R11: A read request returns its data on `rdata_o` with `rvalid_o` high exactly one cycle later. The data is sampled at the request edge. Writes to words 0x00, 0x0C, 0x10, 0x18 and 0x9C change nothing, and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive source lines |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address of a 32-bit word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Leave-idle request |

## Verification
A register write lands on the edge that accepts it. The three outputs are registered from values present at that same edge, so a change made through the bus shows on `irq_o`, `fiq_o` or `wake_o` two edges after it is driven. A change on `src_i` shows one edge after it is driven. The bench checks the outputs on the falling edge after the edge that updates them.

Read results arrive one edge after the request. The driver queues each expected word when it raises the request. The monitor compares the word on the falling edge where `rvalid_o` is high, so every read is matched to its own request.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 32,
  parameter int AW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     src_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            rvalid_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  localparam int IDW = $clog2(NSRC);
  localparam logic [AW-1:0] A_IPEND = AW'(8'h00);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h04);
  localparam logic [AW-1:0] A_STEER = AW'(8'h08);
  localparam logic [AW-1:0] A_FPEND = AW'(8'h0C);
  localparam logic [AW-1:0] A_RAW   = AW'(8'h10);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h14);
  localparam logic [AW-1:0] A_IHP   = AW'(8'h18);
  localparam logic [AW-1:0] A_SLOT0 = AW'(8'h1C);
  localparam logic [AW-1:0] A_FHP   = AW'(8'h1C + 4 * NSLOT);

  logic [31:0] mask_q, steer_q;
  logic        ctrl_q;
  logic [NSLOT-1:0]          slot_v;
  logic [NSLOT-1:0][IDW-1:0] slot_id;

  wire [31:0] live   = src_i & mask_q;
  wire [31:0] i_pend = live & ~steer_q;
  wire [31:0] f_pend = live & steer_q;

  function automatic logic [IDW:0] pick(input logic [31:0] p);
    logic [IDW-1:0] id;
    id = '0;
    for (int i = 0; i < NSRC; i++)
      if (p[i]) id = IDW'(i);
    for (int s = NSLOT - 1; s >= 0; s--)
      if (slot_v[s] && p[slot_id[s]]) id = slot_id[s];
    return {|p, id};
  endfunction

  wire [IDW:0] i_win = pick(i_pend);
  wire [IDW:0] f_win = pick(f_pend);
  wire [31:0] i_word = i_win[IDW] ? {1'b1, {(15-IDW){1'b0}}, i_win[IDW-1:0], 16'b0} : 32'b0;
  wire [31:0] f_word = f_win[IDW] ? {1'b1, {(15-IDW){1'b0}}, f_win[IDW-1:0], 16'b0} : 32'b0;

  wire [AW-1:0] soff    = addr_i - A_SLOT0;
  wire          in_slot = (addr_i >= A_SLOT0) && (addr_i < A_FHP) && (addr_i[1:0] == 2'b00);
  wire          wr      = req_i && we_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      steer_q <= '0;
      ctrl_q  <= 1'b0;
      slot_v  <= '0;
      slot_id <= '0;
    end else if (wr) begin
      if (addr_i == A_MASK)  mask_q  <= wdata_i;
      if (addr_i == A_STEER) steer_q <= wdata_i;
      if (addr_i == A_CTRL)  ctrl_q  <= wdata_i[0];
      for (int s = 0; s < NSLOT; s++)
        if (in_slot && soff[AW-1:2] == (AW-2)'(s)) begin
          slot_v[s]  <= wdata_i[31];
          slot_id[s] <= wdata_i[IDW-1:0];
        end
    end
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    case (addr_i)
      A_IPEND: rmux = i_pend;
      A_MASK:  rmux = mask_q;
      A_STEER: rmux = steer_q;
      A_FPEND: rmux = f_pend;
      A_RAW:   rmux = src_i;
      A_CTRL:  rmux = {31'b0, ctrl_q};
      A_IHP:   rmux = i_word;
      A_FHP:   rmux = f_word;
      default: rmux = '0;
    endcase
    for (int s = 0; s < NSLOT; s++)
      if (in_slot && soff[AW-1:2] == (AW-2)'(s))
        rmux = {slot_v[s], {(31-IDW){1'b0}}, slot_id[s]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
      wake_o   <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rmux;
      irq_o  <= |i_pend;
      fiq_o  <= |f_pend;
      wake_o <= ctrl_q ? |live : |src_i;
    end
  end

  a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'b0) |=> (!irq_o && !fiq_o));
  a_r3_all_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_q == '1) |=> !irq_o);
  a_r10_gated_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q && (src_i & mask_q) == 32'b0) |=> !wake_o);
  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r6_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && addr_i == A_IHP && (src_i & mask_q & ~steer_q) == 32'b0) |=> rdata_o == 32'b0);
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic clk = 0, rst_n = 0;
  logic [31:0] src = 0, wdata = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] rdata;
  logic rvalid, irq, fiq, wake;
  int compared = 0, mismatched = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  localparam logic [31:0] V = 32'h8000_0000;

  always #5 clk = ~clk;

  prio_intc dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake));

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    compared++;
    if (act !== e) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  always @(negedge clk) if (rvalid) begin
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL R11: unexpected read data %h expected none", rdata);
    end else begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      compared++;
      if (rdata !== e) begin
        mismatched++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  function automatic logic [31:0] hp(input int id);
    return V | (32'(id) << 16);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq, 0, "R1 irq"); chk(fiq, 0, "R1 fiq"); chk(wake, 0, "R1 wake");
    rd(8'h04, 0, "R1 mask"); rd(8'h18, 0, "R1 hp"); rd(8'h1C, 0, "R1 slot0");

    src = 32'h0000_00F0;
    rd(8'h10, 32'hF0, "R3 raw");
    rd(8'h00, 0, "R2 masked pending");
    chk(irq, 0, "R2 masked irq");
    chk(wake, 1, "R10 wake any line");
    wr(8'h14, 1); @(negedge clk);
    chk(wake, 0, "R10 wake gated");
    rd(8'h14, 1, "R10 ctrl readback");

    wr(8'h04, 32'h30);
    chk(irq, 0, "R2 mask acts next cycle");
    @(negedge clk);
    chk(irq, 1, "R5 irq"); chk(wake, 1, "R10 enabled wake");
    rd(8'h00, 32'h30, "R3 irq pending");
    rd(8'h18, hp(5), "R8 fallback highest");

    wr(8'h08, 32'h20); @(negedge clk);
    chk(fiq, 1, "R5 fiq");
    rd(8'h00, 32'h10, "R3 irq set");
    rd(8'h0C, 32'h20, "R3 fiq set");
    rd(8'h18, hp(4), "R6 irq winner");
    rd(8'h9C, hp(5), "R9 fiq winner");
    rd(8'h08, 32'h20, "R3 steer readback");

    wr(8'h00, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h9C, 0);
    rd(8'h00, 32'h10, "R11 ro write ignored");
    rd(8'h18, hp(4), "R11 ro hp ignored");
    rd(8'h9C, hp(5), "R11 ro fhp ignored");
    rd(8'hFC, 0, "R11 unmapped");

    wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 0);
    src = 32'h8000_0101;
    rd(8'h18, hp(31), "R8 no slots");
    wr(8'h24, V | 0); wr(8'h30, 32'hFFFF_FF08);
    rd(8'h18, hp(0), "R7 lower slot wins");
    rd(8'h24, V, "R7 slot2 readback");
    rd(8'h30, V | 8, "R7 slot5 readback");
    src = 32'h8000_0100;
    rd(8'h18, hp(8), "R4 R7 cleared line");
    wr(8'h20, 31);
    rd(8'h18, hp(8), "R7 invalid slot skipped");
    wr(8'h1C, V | 31);
    rd(8'h18, hp(31), "R7 slot0 top");
    wr(8'h08, 32'h8000_0000);
    rd(8'h9C, hp(31), "R9 fiq slot");
    rd(8'h18, hp(8), "R9 irq slot after steer");
    wr(8'h08, 0); wr(8'h04, 32'hFFFF_FEFF); wr(8'h1C, 0);
    rd(8'h18, hp(31), "R8 masked slot source");

    src = 0; @(negedge clk);
    chk(irq, 0, "R4 irq drops"); chk(fiq, 0, "R4 fiq drops");
    rd(8'h18, 0, "R6 empty");
    rd(8'h9C, 0, "R9 empty");

    src = 32'h10; @(negedge clk);
    chk(irq, 1, "R5 irq again");
    wr(8'h04, 0); @(negedge clk);
    chk(irq, 0, "R2 mask off");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R11: %0d reads unanswered expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R11: watchdog expired got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule